// File: doc/BRIEF.md
# Dual-Channel Phase-Offset Sine Synthesizer

This block generates two digital sine sample streams for a two-phase ultrasonic motor drive. Each stream goes to its own external DAC. Both streams come from one shared phase accumulator, so they always have the same frequency. Both use the same amplitude scale. Channel B reads the sine table at an address shifted by a programmable offset, which sets the phase difference between the two drive phases. A value of 256 gives a quarter-turn (90°) difference.

A host processor writes a tuning word, a phase offset, an amplitude scale and a run bit into holding registers. A single commit strobe then moves all four into the active configuration in the same cycle. When the active run bit is low, the accumulator is forced to zero and both streams carry the zero code. Toggling the run bit therefore forms bursts of drive for step moves, and each burst starts at phase zero.

The samples leave the block through a valid/ready pair that both channels share. The accumulator advances only when a sample is accepted. While ready is low, the current pair of samples stays on the outputs unchanged, and the phase does not move.

Top module: `dds_dual_phase`

## Requirements
- R1: Each accepted sample pair advances the 32-bit accumulator by the active tuning word K, modulo 2^32. In the k-th pair of a burst, channel A uses table address bits [31:22] of k·K.
- R2: The table value at address a (0..1023) is round(2047·sin(2πa/1024)), rounded half away from zero, as a 12-bit two's-complement number.
- R3: Channel B uses table address (A's address + phase offset) mod 1024. The phase offset is a 10-bit value.
- R4: Each output equals table value × amp / 256, rounded toward zero. The amplitude amp is 8-bit unsigned, so amp = 0 gives the zero code.
- R5: A write to a holding register does not affect the outputs until cfg_commit is high on a clock edge. That edge copies all four holding values into the active configuration together.
- R6: While the active run bit is 0, the accumulator is held at 0 and both outputs carry 0. After a commit that sets run = 1, the first sample pair of the burst (address 0) appears one cycle after the commit edge.
- R7: While smp_valid is high and smp_ready is low, smp_a, smp_b and the phase stay unchanged.
- R8: Reset clears the holding and active registers and sets both outputs to 0. smp_valid is high from the first clock edge after reset and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_ftw_we | input | 1 | Write enable for the tuning word holding register |
| hold_ftw | input | 32 | Tuning word K |
| hold_phs_we | input | 1 | Write enable for the phase offset holding register |
| hold_phs | input | 10 | Phase offset of channel B, in table steps |
| hold_amp_we | input | 1 | Write enable for the amplitude holding register |
| hold_amp | input | 8 | Amplitude scale, unsigned, in units of 1/256 |
| hold_run_we | input | 1 | Write enable for the run holding bit |
| hold_run | input | 1 | Run (1) or stop (0) |
| cfg_commit | input | 1 | Copies all holding registers into the active configuration |
| smp_valid | output | 1 | A sample pair is present |
| smp_ready | input | 1 | The DACs take the present pair |
| smp_a | output | 12 | Channel A sample, two's complement |
| smp_b | output | 12 | Channel B sample, two's complement |

## Verification
A holding write takes effect in the active configuration at the commit edge. The burst's first sample pair is on the outputs one edge after that commit edge. Each further pair appears one edge after the previous pair was accepted. After a stop commit, both outputs read zero from the second edge onward. The bench holds ready high until that first pair is registered, and only then arms the scoreboard. Expected pairs are compared in acceptance order, at the falling edge, while valid and ready are both high. Because of this, neither stalls nor a zero left over from the stopped state can shift the comparison by a sample.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam int ACC_W  = 32;
  localparam int ADDR_W = 10;
  localparam int SMP_W  = 12;
  localparam int AMP_W  = 8;

  // Quarter-wave magnitude for point idx of qpts, rounded to nearest.
  function automatic int quarter_val(int idx, int qpts, int peak);
    real x;
    x = 1.5707963267948966 * real'(idx) / real'(qpts);
    return $rtoi(real'(peak) * $sin(x) + 0.5);
  endfunction

endpackage

// File: rtl/dds_cfg_regs.sv
module dds_cfg_regs #(
  parameter int ACC_W  = dds_pkg::ACC_W,
  parameter int ADDR_W = dds_pkg::ADDR_W,
  parameter int AMP_W  = dds_pkg::AMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ftw_we,
  input  logic [ACC_W-1:0]  ftw_in,
  input  logic              phs_we,
  input  logic [ADDR_W-1:0] phs_in,
  input  logic              amp_we,
  input  logic [AMP_W-1:0]  amp_in,
  input  logic              run_we,
  input  logic              run_in,
  input  logic              commit,
  output logic [ACC_W-1:0]  ftw_q,
  output logic [ADDR_W-1:0] phs_q,
  output logic [AMP_W-1:0]  amp_q,
  output logic              run_q
);

  logic [ACC_W-1:0]  ftw_h;
  logic [ADDR_W-1:0] phs_h;
  logic [AMP_W-1:0]  amp_h;
  logic              run_h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ftw_h <= '0;
      phs_h <= '0;
      amp_h <= '0;
      run_h <= 1'b0;
    end else begin
      if (ftw_we) ftw_h <= ftw_in;
      if (phs_we) phs_h <= phs_in;
      if (amp_we) amp_h <= amp_in;
      if (run_we) run_h <= run_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ftw_q <= '0;
      phs_q <= '0;
      amp_q <= '0;
      run_q <= 1'b0;
    end else if (commit) begin
      ftw_q <= ftw_h;
      phs_q <= phs_h;
      amp_q <= amp_h;
      run_q <= run_h;
    end
  end

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W  = dds_pkg::ACC_W,
  parameter int ADDR_W = dds_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              step_en,
  input  logic [ACC_W-1:0]  ftw,
  output logic [ADDR_W-1:0] phase_top
);

  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (!run)    acc_q <= '0;
    else if (step_en) acc_q <= acc_q + ftw;
  end

  assign phase_top = acc_q[ACC_W-1 -: ADDR_W];

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int ADDR_W = dds_pkg::ADDR_W,
  parameter int SMP_W  = dds_pkg::SMP_W
) (
  input  logic [ADDR_W-1:0]       addr,
  output logic signed [SMP_W-1:0] data
);

  localparam int QBITS = ADDR_W - 2;
  localparam int QPTS  = 1 << QBITS;
  localparam int PEAK  = (1 << (SMP_W - 1)) - 1;

  logic [SMP_W-2:0] qtab [0:QPTS];

  for (genvar i = 0; i <= QPTS; i++) begin : g_q
    localparam int V = dds_pkg::quarter_val(i, QPTS, PEAK);
    assign qtab[i] = V[SMP_W-2:0];
  end

  logic             mirror, negate;
  logic [QBITS:0]   sel;
  logic [SMP_W-2:0] mag;

  always_comb begin
    mirror = addr[ADDR_W-2];
    negate = addr[ADDR_W-1];
    sel    = mirror ? ((QBITS+1)'(QPTS) - {1'b0, addr[QBITS-1:0]})
                    : {1'b0, addr[QBITS-1:0]};
    mag    = qtab[sel];
    data   = negate ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

endmodule

// File: rtl/dds_amp_scale.sv
module dds_amp_scale #(
  parameter int SMP_W = dds_pkg::SMP_W,
  parameter int AMP_W = dds_pkg::AMP_W
) (
  input  logic signed [SMP_W-1:0] smp,
  input  logic [AMP_W-1:0]        amp,
  output logic signed [SMP_W-1:0] y
);

  localparam int PW = SMP_W + AMP_W + 1;
  localparam logic signed [PW-1:0] BIAS = PW'((1 << AMP_W) - 1);

  logic signed [PW-1:0] s_ext, a_ext, prod, biased;
  logic unused_bits;

  always_comb begin
    s_ext  = PW'(smp);
    a_ext  = $signed(PW'({1'b0, amp}));
    prod   = s_ext * a_ext;
    biased = prod + (prod[PW-1] ? BIAS : '0);
    y      = biased[AMP_W +: SMP_W];
  end

  assign unused_bits = &{1'b0, biased[AMP_W-1:0], biased[PW-1]};

endmodule

// File: rtl/dds_dual_phase.sv
module dds_dual_phase #(
  parameter int ACC_W  = dds_pkg::ACC_W,
  parameter int ADDR_W = dds_pkg::ADDR_W,
  parameter int SMP_W  = dds_pkg::SMP_W,
  parameter int AMP_W  = dds_pkg::AMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_ftw_we,
  input  logic [ACC_W-1:0]  hold_ftw,
  input  logic              hold_phs_we,
  input  logic [ADDR_W-1:0] hold_phs,
  input  logic              hold_amp_we,
  input  logic [AMP_W-1:0]  hold_amp,
  input  logic              hold_run_we,
  input  logic              hold_run,
  input  logic              cfg_commit,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [SMP_W-1:0]  smp_a,
  output logic [SMP_W-1:0]  smp_b
);

  localparam int NCH = 2;

  logic [ACC_W-1:0]  act_ftw;
  logic [ADDR_W-1:0] act_phs;
  logic [AMP_W-1:0]  act_amp;
  logic              act_run;
  logic              step_en;
  logic [ADDR_W-1:0] phase_top;
  logic [ADDR_W-1:0] ch_addr [NCH];
  logic signed [SMP_W-1:0] ch_raw [NCH];
  logic signed [SMP_W-1:0] ch_lvl [NCH];

  dds_cfg_regs #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .ftw_we(hold_ftw_we), .ftw_in(hold_ftw),
    .phs_we(hold_phs_we), .phs_in(hold_phs),
    .amp_we(hold_amp_we), .amp_in(hold_amp),
    .run_we(hold_run_we), .run_in(hold_run),
    .commit(cfg_commit),
    .ftw_q(act_ftw), .phs_q(act_phs), .amp_q(act_amp), .run_q(act_run)
  );

  assign step_en = !smp_valid || smp_ready;

  dds_phase_acc #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .run(act_run), .step_en(step_en),
    .ftw(act_ftw), .phase_top(phase_top)
  );

  assign ch_addr[0] = phase_top;
  assign ch_addr[1] = phase_top + act_phs;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dds_sine_rom #(.ADDR_W(ADDR_W), .SMP_W(SMP_W)) u_rom (
      .addr(ch_addr[c]), .data(ch_raw[c])
    );
    dds_amp_scale #(.SMP_W(SMP_W), .AMP_W(AMP_W)) u_scale (
      .smp(ch_raw[c]), .amp(act_amp), .y(ch_lvl[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_a     <= '0;
      smp_b     <= '0;
    end else begin
      smp_valid <= 1'b1;
      if (!act_run) begin
        smp_a <= '0;
        smp_b <= '0;
      end else if (step_en) begin
        smp_a <= ch_lvl[0];
        smp_b <= ch_lvl[1];
      end
    end
  end

endmodule

// File: rtl/dds_dual_phase_chk.sv
module dds_dual_phase_chk #(
  parameter int ACC_W  = dds_pkg::ACC_W,
  parameter int ADDR_W = dds_pkg::ADDR_W,
  parameter int SMP_W  = dds_pkg::SMP_W,
  parameter int AMP_W  = dds_pkg::AMP_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_commit,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic [SMP_W-1:0]  smp_a,
  input logic [SMP_W-1:0]  smp_b,
  input logic [ACC_W-1:0]  acc,
  input logic [ACC_W-1:0]  act_ftw,
  input logic [ADDR_W-1:0] act_phs,
  input logic [AMP_W-1:0]  act_amp,
  input logic              act_run
);

  AST_CFG_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit |=> ($stable(act_ftw) && $stable(act_phs) && $stable(act_amp) && $stable(act_run))); // R5

  AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !act_run |=> (acc == '0 && smp_a == '0 && smp_b == '0)); // R6

  AST_BURST_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_run) |-> acc == '0); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready && act_run && !cfg_commit) |=>
      ($stable(smp_a) && $stable(smp_b) && $stable(acc))); // R7

  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> smp_valid); // R8

endmodule

bind dds_dual_phase dds_dual_phase_chk #(
  .ACC_W(ACC_W), .ADDR_W(ADDR_W), .SMP_W(SMP_W), .AMP_W(AMP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_commit(cfg_commit),
  .smp_valid(smp_valid), .smp_ready(smp_ready),
  .smp_a(smp_a), .smp_b(smp_b), .acc(u_acc.acc_q),
  .act_ftw(act_ftw), .act_phs(act_phs), .act_amp(act_amp), .act_run(act_run)
);

// File: tb/dds_dual_phase_tb.sv
module dds_dual_phase_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold_ftw_we = 0, hold_phs_we = 0, hold_amp_we = 0, hold_run_we = 0;
  logic [31:0] hold_ftw = '0;
  logic [9:0]  hold_phs = '0;
  logic [7:0]  hold_amp = '0;
  logic        hold_run = 1'b0;
  logic        cfg_commit = 1'b0;
  logic        smp_valid;
  logic        smp_ready = 1'b1;
  logic [11:0] smp_a, smp_b;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rdy_mode = 0;
  bit armed = 0;
  string tag = "";
  int qa[$];
  int qb[$];

  always #2 clk = ~clk;

  dds_dual_phase u_dut (
    .clk(clk), .rst_n(rst_n),
    .hold_ftw_we(hold_ftw_we), .hold_ftw(hold_ftw),
    .hold_phs_we(hold_phs_we), .hold_phs(hold_phs),
    .hold_amp_we(hold_amp_we), .hold_amp(hold_amp),
    .hold_run_we(hold_run_we), .hold_run(hold_run),
    .cfg_commit(cfg_commit),
    .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_a(smp_a), .smp_b(smp_b)
  );

  function automatic int sine_ref(int a);
    real r;
    r = 2047.0 * $sin(2.0 * 3.141592653589793 * real'(a) / 1024.0);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    if (rdy_mode == 0) smp_ready = 1'b1;
    else smp_ready = (cyc % 3) != 1;
  end

  // Monitor: compare accepted pairs with the scoreboard queue
  always @(negedge clk) begin
    if (armed && smp_valid && smp_ready && qa.size() > 0) begin
      int ea, eb;
      ea = qa.pop_front();
      eb = qb.pop_front();
      chk({tag, " R1 R2 R4 chA"}, int'($signed(smp_a)), ea);
      chk({tag, " R3 R4 chB"}, int'($signed(smp_b)), eb);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic write_hold(logic [31:0] k, logic [9:0] p, logic [7:0] m, logic r);
    @(posedge clk); #1;
    hold_ftw = k; hold_phs = p; hold_amp = m; hold_run = r;
    hold_ftw_we = 1; hold_phs_we = 1; hold_amp_we = 1; hold_run_we = 1;
    @(posedge clk); #1;
    hold_ftw_we = 0; hold_phs_we = 0; hold_amp_we = 0; hold_run_we = 0;
  endtask

  task automatic commit_now();
    cfg_commit = 1;
    @(posedge clk); #1;
    cfg_commit = 0;
  endtask

  task automatic stop_and_check();
    rdy_mode = 0;
    write_hold(32'h0, 10'd0, 8'd0, 1'b0);
    commit_now();
    @(posedge clk);
    @(negedge clk);
    chk("R6 stop chA", int'($signed(smp_a)), 0);
    chk("R6 stop chB", int'($signed(smp_b)), 0);
  endtask

  task automatic run_burst(logic [31:0] k, logic [9:0] p, logic [7:0] m,
                           int n, int mode, bit poke, string t);
    write_hold(k, p, m, 1'b1);
    commit_now();            // commit edge passed; the first pair loads at the next edge
    @(posedge clk);
    rdy_mode = mode;
    for (int i = 0; i < n; i++) begin
      logic [31:0] ph;
      int aa, ab;
      ph = k * 32'(i);
      aa = int'(ph[31:22]);
      ab = (aa + int'(p)) % 1024;
      qa.push_back(sine_ref(aa) * int'(m) / 256);
      qb.push_back(sine_ref(ab) * int'(m) / 256);
    end
    tag = t;
    #1 armed = 1;
    if (poke) begin
      repeat (7) @(posedge clk);
      #1;
      hold_ftw = 32'h3000_0000; hold_amp = 8'd3; hold_phs = 10'd77;
      hold_ftw_we = 1; hold_amp_we = 1; hold_phs_we = 1;
      @(posedge clk); #1;
      hold_ftw_we = 0; hold_amp_we = 0; hold_phs_we = 0;
    end
    while (qa.size() > 0) @(posedge clk);
    #1 armed = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R8 reset valid", int'(smp_valid), 1);
    chk("R8 reset chA", int'($signed(smp_a)), 0);
    chk("R8 reset chB", int'($signed(smp_b)), 0);

    // One table step per sample, quarter-turn offset, near-full scale
    run_burst(32'h0040_0000, 10'd256, 8'd255, 40, 0, 0, "b1");
    stop_and_check();
    // Irregular step, half-turn offset, stalls, holding writes without commit
    run_burst(32'h0123_4567, 10'd512, 8'd128, 60, 1, 1, "b2 R5 R6 R7");
    stop_and_check();
    // Large step that wraps, offset that wraps the B address, smallest scale
    run_burst(32'hF000_0000, 10'd1000, 8'd1, 30, 1, 0, "b3 R7");
    stop_and_check();
    // Zero amplitude gives zero on both channels
    run_burst(32'h0080_0000, 10'd100, 8'd0, 12, 0, 0, "b4");
    stop_and_check();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule